// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block sits between a clocked host and an external asynchronous static RAM of 65,536 sixteen-bit words. The host hands over one request at a time: an address, write data, a two-bit lane mask and a read/write flag, qualified by a valid/ready handshake. The controller turns that request into a correctly timed sequence on the memory pins. Those pins are active-low chip select, write strobe, output enable, and one strobe for each byte lane. The data bus is split into an output word, a driver enable and an input word, so a tristate pad can be placed outside the block. When the access ends, the block returns a one-cycle response pulse. For reads, the response carries the sampled data.

Each access walks through a setup phase, a strobe phase, a hold phase and, after reads only, a turnaround phase. Every phase length is a whole number of clocks. It is derived at elaboration from nanosecond limits and the clock period parameter as ceil(limit / period), never less than one. The address only moves while every strobe is high. Each byte lane is asserted only when its mask bit is set. A request with an empty mask is answered at once and never touches the memory.

Top module: `async_sram_ctrl`

## Requirements
- R1: `reqReady` is high exactly when the controller is idle. A request is taken on a clock edge where `reqValid` and `reqReady` are both high, and `reqReady` is low in the cycle after a request with a non-zero mask is taken.
- R2: `memAddr` changes only on edges where the chip select, write strobe and both lane strobes are high before and after the edge.
- R3: A write holds chip select, write strobe and the selected lane strobes low together for ceil(50 ns / period) clocks, with output enable high. The data driver is enabled and its word is steady from setup through hold.
- R4: Lane strobe `memLbN` (bits 7:0) is low during the strobe phase only if mask bit 0 is set, and `memUbN` (bits 15:8) only if mask bit 1 is set. Only selected lanes are written. A read returns zero in every lane whose mask bit is clear.
- R5: A read holds chip select, output enable and the selected lane strobes low with the write strobe high for ceil(55 ns / period) clocks. The data is sampled on the edge that ends the strobe phase.
- R6: Setup + strobe + hold covers at least ceil(55 ns / period) clocks. `rspValid` goes high for one cycle after the hold phase. At the default 4 ns period, it rises 15 edges after acceptance for a write and 16 edges after acceptance for a read.
- R7: After a read, the block keeps all strobes high and its data driver off for ceil(20 ns / period) further clocks before it returns to idle. At the default period, `reqReady` rises 5 edges after the read response.
- R8: A request whose mask is 00 gets `rspValid` in the cycle right after acceptance, with `rspRdata` equal to zero. No strobe is asserted and memory contents are unchanged.
- R9: During and after reset, all strobes are high, the data driver is off, `reqReady` is high and `rspValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Read data, zero in unselected lanes |
| memCeN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memLbN | output | 1 | Lower lane strobe, active low |
| memUbN | output | 1 | Upper lane strobe, active low |
| memAddr | output | 16 | Memory address |
| memDqOut | output | 16 | Data to the memory |
| memDqOe | output | 1 | Data driver enable |
| memDqIn | input | 16 | Data from the memory |

## Verification
The bound checker watches every cycle for these conditions:
- the address moving under an active strobe;
- write strobe and output enable low together;
- the data driver being on while output enable is low;
- `reqReady` or `rspValid` coinciding with chip select;
- a chip select with no lane selected.

Some behaviours cannot be seen from a single cycle. These are the strobe overlap lengths, the data setup window before a write ends, the bus release window after a read, lane merging in memory and the response latencies. They are shown only by the bench's clock-counting memory model and its scoreboard. That model returns garbage for any read sampled too early and flags short overlaps or early driver enables.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_TURN
  } phase_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;      // capture request fields
    logic zeroAck;   // empty-mask request, answer at once
    logic selOn;     // chip select phase
    logic wrPulse;   // write strobe low
    logic rdEnable;  // output enable low
    logic drive;     // data driver on
    logic capture;   // sample read data this edge
    logic done;      // access complete this edge
  } ctrl_t;

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int clksFor(int ns, int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_CYCLE_NS    = 55,
  parameter int T_WP_NS       = 45,
  parameter int T_AW_NS       = 50,
  parameter int T_CW_NS       = 50,
  parameter int T_DW_NS       = 25,
  parameter int T_ACC_NS      = 55,
  parameter int T_OE_NS       = 30,
  parameter int T_RELEASE_NS  = 20,
  parameter int LANES         = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic             reqReady,
  output ctrl_t            ctrl
);

  localparam int SETUP_CLKS = clksFor(0, CLK_PERIOD_NS);
  localparam int WR_CLKS    = clksFor(maxOf(maxOf(T_WP_NS, T_AW_NS), maxOf(T_CW_NS, T_DW_NS)), CLK_PERIOD_NS);
  localparam int RD_CLKS    = clksFor(maxOf(T_ACC_NS, T_OE_NS), CLK_PERIOD_NS);
  localparam int CYC_CLKS   = clksFor(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int HOLD_WR    = maxOf(1, CYC_CLKS - SETUP_CLKS - WR_CLKS);
  localparam int HOLD_RD    = maxOf(1, CYC_CLKS - SETUP_CLKS - RD_CLKS);
  localparam int TURN_CLKS  = clksFor(T_RELEASE_NS, CLK_PERIOD_NS);
  localparam int MAX_CLKS   = maxOf(maxOf(maxOf(WR_CLKS, RD_CLKS), maxOf(HOLD_WR, HOLD_RD)), maxOf(TURN_CLKS, SETUP_CLKS));
  localparam int CNT_W      = $clog2(MAX_CLKS + 1);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] LD_WR    = CNT_W'(WR_CLKS - 1);
  localparam logic [CNT_W-1:0] LD_RD    = CNT_W'(RD_CLKS - 1);
  localparam logic [CNT_W-1:0] LD_HWR   = CNT_W'(HOLD_WR - 1);
  localparam logic [CNT_W-1:0] LD_HRD   = CNT_W'(HOLD_RD - 1);
  localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN_CLKS - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             isWr;
  logic             last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
    end else begin
      unique case (phase)
        ST_IDLE: begin
          if (reqValid && (reqMask != '0)) begin
            phase <= ST_SETUP;
            cnt   <= LD_SETUP;
            isWr  <= reqWrite;
          end
        end
        ST_SETUP: begin
          if (last) begin
            phase <= ST_STROBE;
            cnt   <= isWr ? LD_WR : LD_RD;
          end else cnt <= cnt - 1'b1;
        end
        ST_STROBE: begin
          if (last) begin
            phase <= ST_HOLD;
            cnt   <= isWr ? LD_HWR : LD_HRD;
          end else cnt <= cnt - 1'b1;
        end
        ST_HOLD: begin
          if (last) begin
            phase <= isWr ? ST_IDLE : ST_TURN;
            cnt   <= LD_TURN;
          end else cnt <= cnt - 1'b1;
        end
        ST_TURN: begin
          if (last) phase <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign reqReady = (phase == ST_IDLE);

  always_comb begin
    ctrl          = '0;
    ctrl.load     = reqReady && reqValid;
    ctrl.zeroAck  = reqReady && reqValid && (reqMask == '0);
    ctrl.selOn    = (phase == ST_STROBE);
    ctrl.wrPulse  = (phase == ST_STROBE) && isWr;
    ctrl.rdEnable = (phase == ST_STROBE) && !isWr;
    ctrl.drive    = isWr && ((phase == ST_SETUP) || (phase == ST_STROBE) || (phase == ST_HOLD));
    ctrl.capture  = (phase == ST_STROBE) && !isWr && last;
    ctrl.done     = (phase == ST_HOLD) && last;
  end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  laneN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      maskQ  <= '0;
      rdataQ <= '0;
      rspQ   <= 1'b0;
    end else begin
      rspQ <= ctrl.done || ctrl.zeroAck;
      if (ctrl.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
        maskQ <= reqMask;
      end
      if (ctrl.zeroAck) rdataQ <= '0;
      else if (ctrl.capture) begin
        for (int l = 0; l < LANES; l++)
          rdataQ[l*8 +: 8] <= maskQ[l] ? memDqIn[l*8 +: 8] : 8'h00;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneN[g] = ~(ctrl.selOn & maskQ[g]);
  end

  assign memCeN   = ~ctrl.selOn;
  assign memWeN   = ~ctrl.wrPulse;
  assign memOeN   = ~ctrl.rdEnable;
  assign memAddr  = addrQ;
  assign memDqOut = dataQ;
  assign memDqOe  = ctrl.drive;
  assign rspValid = rspQ;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                memCeN,
  output logic                memWeN,
  output logic                memOeN,
  output logic                memLbN,
  output logic                memUbN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memDqOut,
  output logic                memDqOe,
  input  logic [DATA_W-1:0]   memDqIn
);

  localparam int LANES = DATA_W / 8;

  ctrl_t            ctrl;
  logic [LANES-1:0] laneN;

  asram_ctrl_fsm #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .LANES        (LANES)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqMask (reqMask),
    .reqReady(reqReady),
    .ctrl    (ctrl)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .memDqIn (memDqIn),
    .rspValid(rspValid),
    .rspRdata(rspRdata),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .laneN   (laneN),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[LANES-1];

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memLbN,
  input logic              memUbN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memDqOe
);

  logic anyLow;
  assign anyLow = !memCeN || !memWeN || !memLbN || !memUbN;

  // R2: address frozen while any strobe is active
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    anyLow |-> $stable(memAddr));

  // R5: a read never lowers the write strobe
  p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));

  // R3: own driver never fights the memory's output
  p_drive_no_oe_r3: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  // R1: idle means no chip select and no driver
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && !memDqOe));

  // R4: chip select always comes with a lane
  p_lane_sel_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> !(memLbN && memUbN));

  // R7: releasing output enable leaves the driver off
  p_turn_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> !memDqOe);

  // R9: response never overlaps an active access
  p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (memCeN && memWeN && memOeN));

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .memCeN  (memCeN),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memLbN  (memLbN),
  .memUbN  (memUbN),
  .memAddr (memAddr),
  .memDqOe (memDqOe)
);

// File: tb/async_sram_ctrl_tb.sv
`timescale 1ns/1ps
module async_sram_ctrl_tb;

  localparam int PERIOD   = 4;
  localparam int WR_NEED  = (50 + PERIOD - 1) / PERIOD;   // 13
  localparam int RD_NEED  = (55 + PERIOD - 1) / PERIOD;   // 14
  localparam int DS_NEED  = (25 + PERIOD - 1) / PERIOD;   // 7
  localparam int TURN_NEED = (20 + PERIOD - 1) / PERIOD;  // 5
  localparam int CYC_NEED = (55 + PERIOD - 1) / PERIOD;   // 14
  localparam int LAT_WR   = 1 + WR_NEED + ((CYC_NEED - 1 - WR_NEED) > 1 ? (CYC_NEED - 1 - WR_NEED) : 1);
  localparam int LAT_RD   = 1 + RD_NEED + ((CYC_NEED - 1 - RD_NEED) > 1 ? (CYC_NEED - 1 - RD_NEED) : 1);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        rspValid;
  logic [15:0] rspRdata;
  logic        memCeN, memWeN, memOeN, memLbN, memUbN, memDqOe;
  logic [15:0] memAddr, memDqOut;
  logic [15:0] memDqIn = 16'hBEEF;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int selCount = 0;

  always #(PERIOD/2) clk = ~clk;

  async_sram_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspRdata(rspRdata), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memLbN(memLbN), .memUbN(memUbN), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", cycles, 100000);
      finishRun();
    end
  end

  // Behavioural memory with cycle-counted timing rules
  logic [15:0] mem [int];
  logic [15:0] expMem [int];
  logic [15:0] prevAddr = '0;
  bit   prevLow = 0, prevRd = 0;
  int   rdCnt = 0, wrCnt = 0, stableCnt = 0, relCnt = 0;
  logic [15:0] lastData = '0;
  logic [1:0]  lastLanes = '0;
  int   violations = 0;

  function automatic logic [15:0] memRead(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      bit anyLow, rdAct, wrAct;
      logic [15:0] w;
      anyLow = !memCeN || !memWeN || !memLbN || !memUbN;
      rdAct  = !memCeN && !memOeN && memWeN && (!memLbN || !memUbN);
      wrAct  = !memCeN && !memWeN && (!memLbN || !memUbN);
      if (!memCeN) selCount++;
      if (memAddr !== prevAddr && (anyLow || prevLow)) begin
        violations++; check(1'b0, "R2 address moved under strobe", memAddr, prevAddr);
      end
      if (!memWeN && !memOeN) begin
        violations++; check(1'b0, "R5 write strobe with output enable", 1, 0);
      end
      if (memDqOe && (rdAct || relCnt > 0)) begin
        violations++; check(1'b0, "R7 driver on during memory drive window", relCnt, 0);
      end
      if (rdAct) relCnt = TURN_NEED;
      else if (relCnt > 0) relCnt--;
      // read path
      if (rdAct) begin
        rdCnt = (prevRd && memAddr == prevAddr) ? rdCnt + 1 : 1;
        if (rdCnt >= RD_NEED) begin
          w = memRead(memAddr);
          memDqIn <= {(!memUbN ? w[15:8] : 8'hA5), (!memLbN ? w[7:0] : 8'h5A)};
        end else memDqIn <= 16'hDEAD;
      end else begin
        rdCnt = 0;
        memDqIn <= 16'hBEEF;
      end
      // write path
      if (wrAct) begin
        if (!memDqOe) begin
          violations++; check(1'b0, "R3 write without driver", 0, 1);
        end
        if (!memOeN) begin
          violations++; check(1'b0, "R3 output enable low in write", 0, 1);
        end
        stableCnt = (wrCnt > 0 && memDqOut == lastData) ? stableCnt + 1 : 1;
        wrCnt++;
        lastData  = memDqOut;
        lastLanes = {!memUbN, !memLbN};
      end else if (wrCnt > 0) begin
        if (wrCnt < WR_NEED || stableCnt < DS_NEED) begin
          violations++; check(1'b0, "R3 write overlap or data setup short", wrCnt, WR_NEED);
        end
        w = memRead(prevAddr);
        if (lastLanes[0]) w[7:0]  = lastData[7:0];
        if (lastLanes[1]) w[15:8] = lastData[15:8];
        mem[int'(prevAddr)] = w;
        wrCnt = 0;
      end
      prevLow  = anyLow;
      prevRd   = rdAct;
      prevAddr = memAddr;
    end
  end

  function automatic logic [15:0] expRead(input logic [15:0] a, input logic [1:0] m);
    logic [15:0] v;
    v = expMem.exists(int'(a)) ? expMem[int'(a)] : 16'h0000;
    return {(m[1] ? v[15:8] : 8'h00), (m[0] ? v[7:0] : 8'h00)};
  endfunction

  task automatic doReq(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] m, output logic [15:0] rd, output int lat, output int turn);
    while (!reqReady) @(posedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    check(reqReady == (m == 2'b00), "R1 ready after accept", reqReady, (m == 2'b00));
    lat = 0;
    while (!rspValid) begin
      @(posedge clk); #1; lat++;
      if (lat > 1000) break;
    end
    rd = rspRdata;
    turn = 0;
    while (!reqReady) begin
      @(posedge clk); #1; turn++;
      if (turn > 1000) break;
    end
    if (wr) begin
      logic [15:0] v;
      v = expMem.exists(int'(a)) ? expMem[int'(a)] : 16'h0000;
      if (m[0]) v[7:0]  = d[7:0];
      if (m[1]) v[15:8] = d[15:8];
      expMem[int'(a)] = v;
    end
  endtask

  task automatic wrChk(input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] rd; int lat, turn;
    doReq(1'b1, a, d, m, rd, lat, turn);
    check(lat == LAT_WR, "R6 write latency", lat, LAT_WR);
    check(turn == 0, "R7 no turnaround after write", turn, 0);
  endtask

  task automatic rdChk(input logic [15:0] a, input logic [1:0] m, input string tag);
    logic [15:0] rd, e; int lat, turn;
    e = expRead(a, m);
    doReq(1'b0, a, 16'h0, m, rd, lat, turn);
    check(rd == e, tag, rd, e);
    check(lat == LAT_RD, "R5 read latency", lat, LAT_RD);
    check(turn == TURN_NEED, "R7 turnaround after read", turn, TURN_NEED);
  endtask

  initial begin
    logic [15:0] rd; int lat, turn, sel0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check({memCeN, memWeN, memOeN, memLbN, memUbN} == 5'b11111, "R9 strobes idle in reset",
          {memCeN, memWeN, memOeN, memLbN, memUbN}, 5'b11111);
    check(!memDqOe && reqReady && !rspValid, "R9 driver off ready high",
          {memDqOe, reqReady, rspValid}, 3'b010);
    rstN = 1'b1;
    @(posedge clk); #1;
    check({memCeN, memLbN, memUbN, memDqOe, reqReady} == 5'b11101, "R9 state after reset",
          {memCeN, memLbN, memUbN, memDqOe, reqReady}, 5'b11101);

    // R3 R6: full word write, R5 read back
    wrChk(16'h0010, 16'h1234, 2'b11);
    rdChk(16'h0010, 2'b11, "R5 full read");
    // R4: lower lane only, then upper lane only
    wrChk(16'h0010, 16'hABCD, 2'b01);
    rdChk(16'h0010, 2'b11, "R4 lower lane write");
    wrChk(16'h0010, 16'h5678, 2'b10);
    rdChk(16'h0010, 2'b11, "R4 upper lane write");
    rdChk(16'h0010, 2'b01, "R4 upper lane zero on read");
    rdChk(16'h0010, 2'b10, "R4 lower lane zero on read");

    // R8: empty mask write and read
    sel0 = selCount;
    doReq(1'b1, 16'h0010, 16'hFFFF, 2'b00, rd, lat, turn);
    check(lat == 0, "R8 empty write ack", lat, 0);
    doReq(1'b0, 16'h0010, 16'h0000, 2'b00, rd, lat, turn);
    check(lat == 0 && rd == 16'h0000, "R8 empty read zero", rd, 0);
    check(selCount == sel0, "R8 no strobe", selCount, sel0);
    rdChk(16'h0010, 2'b11, "R8 memory unchanged");

    // R2: address extremes
    wrChk(16'h0000, 16'hA0A0, 2'b11);
    wrChk(16'hFFFF, 16'h0F0F, 2'b11);
    rdChk(16'h0000, 2'b11, "R2 address zero");
    rdChk(16'hFFFF, 2'b11, "R2 address top");

    // mixed sweep, write right after read
    for (int i = 0; i < 8; i++) begin
      wrChk(16'(i * 16'h1111 + 3), 16'(16'h3C00 + i * 16'h0101), 2'(i % 3 + 1));
      rdChk(16'(i * 16'h1111 + 3), 2'b11, "R4 sweep read");
    end

    check(violations == 0, "R3 timing model clean", violations, 0);
    repeat (4) @(posedge clk);
    finishRun();
  end

endmodule